// File: doc/BRIEF.md
# Even-Step Mode Counter

This block produces a small even-valued count whose direction and override come from a two-bit mode input. One free-running position register steps once per clock. A combinational decoder turns the position and the mode into the output word. The two counting modes give ascending or descending multiples of two. The two hold modes force the word to all zeros or to all ones.

The position keeps advancing while a hold mode is selected, so the count resumes further along once counting returns. The output is decoded straight from the mode pins. A mode change therefore shows on the output in the same cycle, with no clock edge in between. A synchronous, active-high reset returns the position to its first step.

Top module: `even_step_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the position goes to its first step. In the cycle after reset, mode 00 gives `value` 0 and mode 01 gives `value` 6.
- R2: Mode 00 (ascending) gives the repeating sequence 0, 2, 4, 6, with one step per clock.
- R3: Mode 01 (descending) gives the repeating sequence 6, 4, 2, 0, with one step per clock. For any position it equals 6 minus the ascending value.
- R4: Mode 10 (clear) holds `value` at 000.
- R5: Mode 11 (preset) holds `value` at 111.
- R6: In modes 00 and 01, bit 0 of `value` is always 0.
- R7: The position advances on every clock edge without reset, whatever the mode. After k cycles in a hold mode, counting resumes k steps further along than where it stopped.
- R8: A change of `mode_sel` changes `value` in the same cycle, decoded from the unchanged position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the position |
| mode_sel | input | 2 | 00 ascending, 01 descending, 10 clear, 11 preset |
| value | output | 3 | Decoded even count or forced pattern |

## Verification
The step properties assume that `mode_sel` only changes between rising edges and stays steady across each edge. They also assume a reset is applied before anything is compared. The bench drives the mode and reset on falling edges, holds reset for two cycles at the start, and gives the checker an arm flag so that nothing is judged before that first reset. Mid-sequence mode switches, hold intervals of several lengths, and a reset in descending mode are compared with a behavioural position model.

// File: rtl/even_step_pkg.sv
package even_step_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_CLEAR  = 2'b10,
        MODE_PRESET = 2'b11
    } mode_t;

    // Hold modes share the high mode bit; counting modes leave it low.
    function automatic logic is_counting(input mode_t m);
        return (m == MODE_UP) || (m == MODE_DOWN);
    endfunction

endpackage

// File: rtl/esc_step_counter.sv
module esc_step_counter #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STEP_W-1:0] pos
);
    logic [STEP_W-1:0] pos_r;

    always_ff @(posedge clk) begin
        if (rst) pos_r <= '0;
        else     pos_r <= pos_r + 1'b1;
    end

    assign pos = pos_r;
endmodule

// File: rtl/esc_out_decode.sv
module esc_out_decode
    import even_step_pkg::*;
#(
    parameter int STEP_W = 2,
    localparam int OUT_W = STEP_W + 1
) (
    input  logic [STEP_W-1:0] pos,
    input  mode_t             mode,
    output logic [OUT_W-1:0]  value
);
    logic [STEP_W-1:0] upper;

    always_comb begin
        upper = (mode == MODE_DOWN) ? ~pos : pos;
        case (mode)
            MODE_CLEAR:  value = '0;
            MODE_PRESET: value = '1;
            default:     value = {upper, 1'b0};
        endcase
    end
endmodule

// File: rtl/even_step_counter.sv
module even_step_counter
    import even_step_pkg::*;
#(
    parameter int STEP_W = 2,
    localparam int OUT_W = STEP_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    output logic [OUT_W-1:0] value
);
    logic [STEP_W-1:0] pos_q;
    mode_t             mode;

    assign mode = mode_t'(mode_sel);

    esc_step_counter #(.STEP_W(STEP_W)) u_step (
        .clk (clk),
        .rst (rst),
        .pos (pos_q)
    );

    esc_out_decode #(.STEP_W(STEP_W)) u_dec (
        .pos   (pos_q),
        .mode  (mode),
        .value (value)
    );
endmodule

// File: rtl/even_step_counter_chk.sv
module even_step_counter_chk #(
    parameter int STEP_W = 2,
    localparam int OUT_W = STEP_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_sel,
    input logic [OUT_W-1:0]  value,
    input logic [STEP_W-1:0] pos
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1: the cycle after a reset starts at the first step
    a_r1_reset_start: assert property (@(posedge clk) disable iff (rst)
        ($past(armed) && $past(rst)) |-> (pos == '0));

    // R2: ascending mode adds two per clock, wrapping
    a_r2_up_step: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(armed) && !$past(rst) && mode_sel == 2'b00 && $past(mode_sel) == 2'b00)
        |-> (value == OUT_W'($past(value) + OUT_W'(2))));

    // R3: descending mode subtracts two per clock, wrapping
    a_r3_down_step: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(armed) && !$past(rst) && mode_sel == 2'b01 && $past(mode_sel) == 2'b01)
        |-> (value == OUT_W'($past(value) - OUT_W'(2))));

    // R4: clear mode holds all zeros
    a_r4_clear: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode_sel == 2'b10) |-> (value == '0));

    // R5: preset mode holds all ones
    a_r5_preset: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode_sel == 2'b11) |-> (value == '1));

    // R6: counting modes never set the low bit
    a_r6_even_lsb: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode_sel[1] == 1'b0) |-> (value[0] == 1'b0));

    // R7: the position steps every clock regardless of mode
    a_r7_advance: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(armed) && !$past(rst)) |-> (pos == STEP_W'($past(pos) + 1'b1)));
endmodule

bind even_step_counter even_step_counter_chk #(.STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .value    (value),
    .pos      (pos_q)
);

// File: tb/even_step_counter_test.sv
module even_step_counter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic [2:0] value;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural model of the position
    int  model_pos = 0;
    bit  model_valid = 0;
    bit  prev_rst = 1;
    logic [1:0] prev_mode = 2'b00;

    even_step_counter uut (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .value    (value)
    );

    always #4 clk = ~clk;

    function automatic int expect_value(input logic [1:0] m, input int p);
        case (m)
            2'b00:   return 2 * p;
            2'b01:   return 6 - 2 * p;
            2'b10:   return 0;
            default: return 7;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: value=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input bit r, input logic [1:0] m);
        string tag;
        @(negedge clk);
        rst = r;
        mode_sel = m;
        #1;
        if (model_valid) begin
            if (prev_rst)                              tag = "R1";
            else if (m != prev_mode)                   tag = "R8";
            else if (prev_mode[1] && !m[1])            tag = "R7";
            else if (m == 2'b00)                       tag = "R2";
            else if (m == 2'b01)                       tag = "R3";
            else if (m == 2'b10)                       tag = "R4";
            else                                       tag = "R5";
            check(tag, int'(value), expect_value(m, model_pos));
            if (!m[1]) check("R6", int'(value[0]), 0);
        end
        prev_mode = m;
        prev_rst = r;
        @(posedge clk);
        if (r) begin
            model_pos = 0;
            model_valid = 1;
        end else begin
            model_pos = (model_pos + 1) % 4;
        end
    endtask

    task automatic run(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) step(1'b0, m);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1'b1, 2'b00);
        step(1'b1, 2'b00);
        // R1 reset state, then R2 two full ascending cycles
        run(2'b00, 9);
        // R3 two full descending cycles (switch itself is R8)
        run(2'b01, 9);
        // R4 and R5 hold modes
        run(2'b10, 5);
        run(2'b11, 5);
        // R7 resume after holds of different lengths
        run(2'b00, 3);
        run(2'b10, 3);
        run(2'b00, 2);
        run(2'b11, 2);
        run(2'b01, 3);
        run(2'b10, 1);
        run(2'b01, 2);
        // R8 switches in mid-sequence every cycle
        for (int k = 0; k < 24; k++) step(1'b0, 2'((k * 3 + k / 4) % 4));
        run(2'b00, 1);
        run(2'b01, 1);
        run(2'b00, 1);
        run(2'b01, 1);
        // R1 reset in descending mode mid-run
        run(2'b01, 2);
        step(1'b1, 2'b01);
        run(2'b01, 6);
        step(1'b1, 2'b00);
        run(2'b00, 4);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule